// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control unit beside a processor core that turns an accepted interrupt into a change of flow. It watches the request lines every cycle and remembers the best request that the current status word lets through. It waits until the core signals that the running instruction has finished. Then it walks a fixed sequence. First it writes the return PC and the status word to a stack memory. Next it clears the interrupt-enable bit, then writes the accepted level into the level field, and last it loads the handler address into the program counter. While it does this a busy flag stalls instruction fetch.

The reverse sequence runs when the core reports that a return-from-interrupt instruction has completed. The block reads the saved words back, restores the status word and resumes at the saved PC. The status word and the PC registers live in this block. The core supplies the next sequential PC with each instruction-boundary strobe, and software may overwrite the status word whenever no sequence is running. When the core is halted, an acceptable request raises a wake output at once. The handler is entered at the first instruction boundary after that, so exactly one instruction runs first.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is sampled and held in every cycle, even if it drops again, but no stack write or busy happens until a cycle in which `insn_done_i` is high while a request is held; the first stack write comes in the cycle after that boundary.
- R2: A non-maskable request is always taken. A maskable one is taken only when status bit 4 (enable) is 1 and its level is strictly greater than status bits 7:5 (current level); otherwise it has no effect.
- R3: With the two-word save layout, entry writes the PC word (PC in bits 23:0, upper bits zero) to SP-1 and then the status word (status in bits 31:24, lower bits zero) to SP-2, in consecutive cycles. SP finishes two lower than it started.
- R4: After the stack writes, the enable bit clears in the following cycle. The level field takes the accepted level one cycle later. The PC takes the vector one cycle after that, and `req_ack_o` is high in the cycle just before the PC changes.
- R5: Entry through a non-maskable request leaves bits 7:5 of the status word unchanged.
- R6: `busy_o` is high from the first stack-write cycle through the cycle before the new PC appears, and low when no sequence runs.
- R7: A return (`reti_i` with `insn_done_i`) reads address SP and then SP+1, with one cycle of read latency. It restores the status word from bits 31:24 of the first word and the PC from bits 23:0 of the second. SP ends two higher.
- R8: While `halt_i` is high, an acceptable request drives `wake_o` high in the same cycle with no busy, and the handler is entered at the first instruction boundary that follows.
- R9: Status bits other than bits 4 and 7:5 pass through entry unchanged.
- R10: After reset the status word and PC are zero, SP equals its reset parameter and busy is low. A software status write takes effect on the next edge when no sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_done_i | input | 1 | Current instruction has completed |
| pc_next_i | input | 24 | PC following the completed instruction |
| reti_i | input | 1 | Completed instruction was a return-from-interrupt |
| halt_i | input | 1 | Core is in a halt or sleep state |
| req_valid_i | input | 1 | Interrupt request present |
| req_level_i | input | 3 | Level of the request |
| req_vector_i | input | 24 | Handler address of the request |
| req_nmi_i | input | 1 | Request is non-maskable |
| req_ack_o | output | 1 | Request entered, handler load this cycle |
| wake_o | output | 1 | Acceptable request seen while halted |
| busy_o | output | 1 | Sequence in progress, stall fetch |
| psr_we_i | input | 1 | Software status-word write |
| psr_wdata_i | input | 8 | Software status-word value |
| psr_o | output | 8 | Current status word |
| pc_o | output | 24 | Current program counter |
| sp_o | output | 16 | Current stack pointer |
| stk_we_o | output | 1 | Stack write strobe |
| stk_re_o | output | 1 | Stack read strobe |
| stk_addr_o | output | 16 | Stack word address |
| stk_wdata_o | output | 32 | Stack write data |
| stk_rdata_i | input | 32 | Stack read data, valid one cycle after the read strobe |

## Verification
The bench builds the block with its default parameters: a 24-bit PC, 32-bit stack words, a 16-bit stack pointer starting at 0x100, and the two-word save layout. That layout makes the push order and the pop order visible as separate stack cycles, so nesting an NMI on top of a maskable entry and then unwinding both returns checks the address arithmetic and the word placement in both directions. The 3-bit level field lets the bench probe the strict greater-than rule at its boundary, with equal and one-higher levels.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PUSH_A,
      ST_PUSH_B,
      ST_CLR_IE,
      ST_SET_IL,
      ST_LOAD,
      ST_POP_A,
      ST_POP_B,
      ST_POP_C
   } seq_state_e;

   typedef enum logic [1:0] {
      SP_HOLD,
      SP_DEC,
      SP_INC
   } sp_op_e;

endpackage

// File: rtl/irq_req_filter.sv
module irq_req_filter #(
   parameter int LVL_W = 3,
   parameter int PC_W  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid_i,
   input  logic [LVL_W-1:0] req_level_i,
   input  logic [PC_W-1:0]  req_vector_i,
   input  logic             req_nmi_i,
   input  logic             ie_i,
   input  logic [LVL_W-1:0] il_i,
   input  logic             hold_i,
   input  logic             clear_i,
   output logic             take_o,
   output logic             pend_o,
   output logic [LVL_W-1:0] pend_level_o,
   output logic [PC_W-1:0]  pend_vector_o,
   output logic             pend_nmi_o
);

   logic better;

   // A request passes if it is non-maskable, or enabled and above the current level
   assign take_o = req_valid_i && (req_nmi_i || (ie_i && (req_level_i > il_i)));

   always_comb begin
      if (!pend_o)
         better = 1'b1;
      else if (pend_nmi_o)
         better = 1'b0;
      else if (req_nmi_i)
         better = 1'b1;
      else
         better = (req_level_i > pend_level_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o        <= 1'b0;
         pend_level_o  <= '0;
         pend_vector_o <= '0;
         pend_nmi_o    <= 1'b0;
      end else if (clear_i) begin
         pend_o     <= 1'b0;
         pend_nmi_o <= 1'b0;
      end else if (!hold_i && take_o && better) begin
         pend_o        <= 1'b1;
         pend_level_o  <= req_level_i;
         pend_vector_o <= req_vector_i;
         pend_nmi_o    <= req_nmi_i;
      end
   end

   a_r2_pend_needs_take : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o) |-> $past(take_o));

endmodule

// File: rtl/irq_sp_ctrl.sv
module irq_sp_ctrl
   import irq_seq_pkg::*;
#(
   parameter int             SP_W     = 16,
   parameter logic [SP_W-1:0] SP_RESET = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  sp_op_e          op_i,
   output logic [SP_W-1:0] sp_o,
   output logic [SP_W-1:0] sp_dec_o
);

   localparam logic [SP_W-1:0] ONE = SP_W'(1);

   assign sp_dec_o = sp_o - ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_o <= SP_RESET;
      else begin
         case (op_i)
            SP_DEC:  sp_o <= sp_o - ONE;
            SP_INC:  sp_o <= sp_o + ONE;
            default: sp_o <= sp_o;
         endcase
      end
   end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int               PSR_W     = 8,
   parameter int               IE_BIT    = 4,
   parameter int               IL_LSB    = 5,
   parameter int               LVL_W     = 3,
   parameter logic [PSR_W-1:0] PSR_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restore_i,
   input  logic [PSR_W-1:0] restore_data_i,
   input  logic             clr_ie_i,
   input  logic             set_il_i,
   input  logic [LVL_W-1:0] il_val_i,
   input  logic             sw_we_i,
   input  logic [PSR_W-1:0] sw_data_i,
   output logic [PSR_W-1:0] psr_o,
   output logic             ie_o,
   output logic [LVL_W-1:0] il_o
);

   assign ie_o = psr_o[IE_BIT];
   assign il_o = psr_o[IL_LSB +: LVL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         psr_o <= PSR_RESET;
      else if (restore_i)
         psr_o <= restore_data_i;
      else if (clr_ie_i)
         psr_o[IE_BIT] <= 1'b0;
      else if (set_il_i)
         psr_o[IL_LSB +: LVL_W] <= il_val_i;
      else if (sw_we_i)
         psr_o <= sw_data_i;
   end

   a_r9_clr_keeps_rest : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ie_i && !restore_i) |=> (psr_o[IL_LSB +: LVL_W] == $past(psr_o[IL_LSB +: LVL_W])));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int               PC_W       = 24,
   parameter int               WORD_W     = 32,
   parameter int               PSR_W      = 8,
   parameter int               LVL_W      = 3,
   parameter int               IE_BIT     = 4,
   parameter int               IL_LSB     = 5,
   parameter int               SP_W       = 16,
   parameter logic [SP_W-1:0]  SP_RESET   = 16'h0100,
   parameter logic [PSR_W-1:0] PSR_RESET  = '0,
   parameter bit               SPLIT_SAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_done_i,
   input  logic [PC_W-1:0]   pc_next_i,
   input  logic              reti_i,
   input  logic              halt_i,
   input  logic              req_valid_i,
   input  logic [LVL_W-1:0]  req_level_i,
   input  logic [PC_W-1:0]   req_vector_i,
   input  logic              req_nmi_i,
   output logic              req_ack_o,
   output logic              wake_o,
   output logic              busy_o,
   input  logic              psr_we_i,
   input  logic [PSR_W-1:0]  psr_wdata_i,
   output logic [PSR_W-1:0]  psr_o,
   output logic [PC_W-1:0]   pc_o,
   output logic [SP_W-1:0]   sp_o,
   output logic              stk_we_o,
   output logic              stk_re_o,
   output logic [SP_W-1:0]   stk_addr_o,
   output logic [WORD_W-1:0] stk_wdata_o,
   input  logic [WORD_W-1:0] stk_rdata_i
);

   localparam int FILL_W = WORD_W - PSR_W;

   // Elaboration-time parameter checks
   if (PC_W + PSR_W > WORD_W) begin : g_bad_word
      $error("stack word too narrow for PC and status");
   end
   if (IL_LSB + LVL_W > PSR_W) begin : g_bad_il
      $error("level field outside status word");
   end
   if (IE_BIT >= IL_LSB && IE_BIT < IL_LSB + LVL_W) begin : g_bad_ie
      $error("enable bit overlaps level field");
   end

   seq_state_e       state, state_nx;
   sp_op_e           sp_op;
   logic [SP_W-1:0]  sp_dec;
   logic             ie, take, pend, pend_nmi;
   logic [LVL_W-1:0] il, pend_level;
   logic [PC_W-1:0]  pend_vector;
   logic             restore;
   logic             last_push, last_pop;
   logic [WORD_W-1:0] word_pc, word_psr, push_data;
   logic [PSR_W-1:0]  pop_psr;
   logic [PC_W-1:0]   pop_pc;

   assign word_pc  = WORD_W'(pc_o);
   assign word_psr = {psr_o, {FILL_W{1'b0}}};
   assign pop_psr  = stk_rdata_i[WORD_W-1 -: PSR_W];
   assign pop_pc   = stk_rdata_i[PC_W-1:0];

   // Save layout: separate PC and status words, or both packed into one
   if (SPLIT_SAVE) begin : g_split
      assign push_data = (state == ST_PUSH_A) ? word_pc : word_psr;
      assign last_push = (state == ST_PUSH_B);
      assign last_pop  = (state == ST_POP_C);
      assign stk_re_o  = (state == ST_POP_A) || (state == ST_POP_B);
   end else begin : g_packed
      assign push_data = word_pc | word_psr;
      assign last_push = (state == ST_PUSH_A);
      assign last_pop  = (state == ST_POP_B);
      assign stk_re_o  = (state == ST_POP_A);
   end

   irq_req_filter #(.LVL_W(LVL_W), .PC_W(PC_W)) u_filter (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .req_level_i  (req_level_i),
      .req_vector_i (req_vector_i),
      .req_nmi_i    (req_nmi_i),
      .ie_i         (ie),
      .il_i         (il),
      .hold_i       (busy_o),
      .clear_i      (req_ack_o),
      .take_o       (take),
      .pend_o       (pend),
      .pend_level_o (pend_level),
      .pend_vector_o(pend_vector),
      .pend_nmi_o   (pend_nmi)
   );

   irq_sp_ctrl #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_sp (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (sp_op),
      .sp_o    (sp_o),
      .sp_dec_o(sp_dec)
   );

   irq_status_reg #(
      .PSR_W(PSR_W), .IE_BIT(IE_BIT), .IL_LSB(IL_LSB),
      .LVL_W(LVL_W), .PSR_RESET(PSR_RESET)
   ) u_psr (
      .clk           (clk),
      .rst_n         (rst_n),
      .restore_i     (restore),
      .restore_data_i(pop_psr),
      .clr_ie_i      (state == ST_CLR_IE),
      .set_il_i      ((state == ST_SET_IL) && !pend_nmi),
      .il_val_i      (pend_level),
      .sw_we_i       (psr_we_i && (state == ST_IDLE)),
      .sw_data_i     (psr_wdata_i),
      .psr_o         (psr_o),
      .ie_o          (ie),
      .il_o          (il)
   );

   assign busy_o      = (state != ST_IDLE);
   assign req_ack_o   = (state == ST_LOAD);
   assign wake_o      = halt_i && take && !busy_o;
   assign stk_we_o    = (state == ST_PUSH_A) || (state == ST_PUSH_B);
   assign stk_addr_o  = stk_we_o ? sp_dec : sp_o;
   assign stk_wdata_o = push_data;
   assign restore     = (state == ST_POP_B);

   always_comb begin
      if (stk_we_o)
         sp_op = SP_DEC;
      else if (stk_re_o)
         sp_op = SP_INC;
      else
         sp_op = SP_HOLD;
   end

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: begin
            if (insn_done_i && reti_i)
               state_nx = ST_POP_A;
            else if (insn_done_i && pend)
               state_nx = ST_PUSH_A;
         end
         ST_PUSH_A: state_nx = last_push ? ST_CLR_IE : ST_PUSH_B;
         ST_PUSH_B: state_nx = ST_CLR_IE;
         ST_CLR_IE: state_nx = ST_SET_IL;
         ST_SET_IL: state_nx = ST_LOAD;
         ST_LOAD:   state_nx = ST_IDLE;
         ST_POP_A:  state_nx = ST_POP_B;
         ST_POP_B:  state_nx = last_pop ? ST_IDLE : ST_POP_C;
         ST_POP_C:  state_nx = ST_IDLE;
         default:   state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= state_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_o <= '0;
      else if ((state == ST_IDLE) && insn_done_i)
         pc_o <= pc_next_i;
      else if (state == ST_LOAD)
         pc_o <= pend_vector;
      else if (busy_o && last_pop)
         pc_o <= pop_pc;
   end

   a_r1_start_at_boundary : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(insn_done_i));

   a_r3_push_lowers_sp : assert property (@(posedge clk) disable iff (!rst_n)
      stk_we_o |=> (sp_o == $past(sp_o) - SP_W'(1)));

   a_r7_pop_raises_sp : assert property (@(posedge clk) disable iff (!rst_n)
      stk_re_o |=> (sp_o == $past(sp_o) + SP_W'(1)));

   a_r4_ack_after_ie_clear : assert property (@(posedge clk) disable iff (!rst_n)
      req_ack_o |-> !psr_o[IE_BIT]);

   a_r5_nmi_level_kept : assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_SET_IL) && pend_nmi) |=> $stable(psr_o[IL_LSB +: LVL_W]));

   a_r8_wake_only_idle : assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> !busy_o);

   a_r6_no_mem_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (stk_we_o || stk_re_o) |-> busy_o);

endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_done_i = 1'b0;
   logic [23:0] pc_next_i = '0;
   logic        reti_i = 1'b0;
   logic        halt_i = 1'b0;
   logic        req_valid_i = 1'b0;
   logic [2:0]  req_level_i = '0;
   logic [23:0] req_vector_i = '0;
   logic        req_nmi_i = 1'b0;
   logic        req_ack_o, wake_o, busy_o;
   logic        psr_we_i = 1'b0;
   logic [7:0]  psr_wdata_i = '0;
   logic [7:0]  psr_o;
   logic [23:0] pc_o;
   logic [15:0] sp_o;
   logic        stk_we_o, stk_re_o;
   logic [15:0] stk_addr_o;
   logic [31:0] stk_wdata_o;
   logic [31:0] stk_rdata_i = '0;

   logic [31:0] mem [0:255];
   int checks = 0;
   int errors = 0;
   logic [15:0] exp_sp;

   always #2.5 clk = ~clk;

   irq_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .insn_done_i(insn_done_i), .pc_next_i(pc_next_i),
      .reti_i(reti_i), .halt_i(halt_i), .req_valid_i(req_valid_i),
      .req_level_i(req_level_i), .req_vector_i(req_vector_i), .req_nmi_i(req_nmi_i),
      .req_ack_o(req_ack_o), .wake_o(wake_o), .busy_o(busy_o),
      .psr_we_i(psr_we_i), .psr_wdata_i(psr_wdata_i), .psr_o(psr_o), .pc_o(pc_o),
      .sp_o(sp_o), .stk_we_o(stk_we_o), .stk_re_o(stk_re_o), .stk_addr_o(stk_addr_o),
      .stk_wdata_o(stk_wdata_o), .stk_rdata_i(stk_rdata_i)
   );

   // Stack memory model with one cycle of read latency
   always @(posedge clk) begin
      if (stk_we_o) mem[stk_addr_o[7:0]] <= stk_wdata_o;
      if (stk_re_o) stk_rdata_i <= mem[stk_addr_o[7:0]];
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic raise_req(input logic [2:0] lvl, input logic [23:0] vec, input logic nmi);
      req_valid_i = 1'b1; req_level_i = lvl; req_vector_i = vec; req_nmi_i = nmi;
   endtask

   task automatic drop_req();
      req_valid_i = 1'b0; req_nmi_i = 1'b0;
   endtask

   task automatic sw_psr(input logic [7:0] v);
      psr_we_i = 1'b1; psr_wdata_i = v;
      tick();
      psr_we_i = 1'b0;
      chk("R10 software status write", {24'h0, psr_o}, {24'h0, v});
   endtask

   // Boundary strobe with a request held; walks the entry sequence cycle by cycle
   task automatic do_entry(input logic [2:0] lvl, input logic [23:0] vec, input logic nmi,
                           input logic [23:0] pcn, input logic [7:0] psr_b);
      logic [7:0] psr_a;
      psr_a = psr_b & 8'hEF;
      if (!nmi) psr_a = {lvl, psr_a[4:0]};
      insn_done_i = 1'b1; pc_next_i = pcn;
      tick();
      insn_done_i = 1'b0;
      drop_req();
      chk("R3 first write strobe", {31'h0, stk_we_o}, 32'h1);
      chk("R6 busy on first write", {31'h0, busy_o}, 32'h1);
      chk("R3 PC word address", {16'h0, stk_addr_o}, {16'h0, exp_sp - 16'd1});
      chk("R3 PC word data", stk_wdata_o, {8'h00, pcn});
      tick();
      chk("R3 status word address", {16'h0, stk_addr_o}, {16'h0, exp_sp - 16'd2});
      chk("R3 status word data", stk_wdata_o, {psr_b, 24'h0});
      tick();
      chk("R4 writes over before IE clear", {31'h0, stk_we_o}, 32'h0);
      chk("R4 status untouched during writes", {24'h0, psr_o}, {24'h0, psr_b});
      tick();
      chk("R4 IE cleared first", {31'h0, psr_o[4]}, 32'h0);
      chk("R4 level not yet set", {29'h0, psr_o[7:5]}, {29'h0, psr_b[7:5]});
      tick();
      chk(nmi ? "R5 NMI level kept" : "R4 level set", {24'h0, psr_o}, {24'h0, psr_a});
      chk("R4 ack in load cycle", {31'h0, req_ack_o}, 32'h1);
      chk("R6 busy in load cycle", {31'h0, busy_o}, 32'h1);
      tick();
      chk("R4 PC loaded with vector", {8'h0, pc_o}, {8'h0, vec});
      chk("R6 busy dropped", {31'h0, busy_o}, 32'h0);
      chk("R9 other status bits kept", {28'h0, psr_o[3:0]}, {28'h0, psr_b[3:0]});
      exp_sp = exp_sp - 16'd2;
      chk("R3 SP lowered by two", {16'h0, sp_o}, {16'h0, exp_sp});
   endtask

   task automatic do_reti(input logic [7:0] psr_e, input logic [23:0] pc_e);
      insn_done_i = 1'b1; reti_i = 1'b1;
      tick();
      insn_done_i = 1'b0; reti_i = 1'b0;
      chk("R7 first read strobe", {31'h0, stk_re_o}, 32'h1);
      chk("R7 first read address", {16'h0, stk_addr_o}, {16'h0, exp_sp});
      tick();
      chk("R7 second read address", {16'h0, stk_addr_o}, {16'h0, exp_sp + 16'd1});
      tick();
      chk("R7 status restored", {24'h0, psr_o}, {24'h0, psr_e});
      tick();
      chk("R7 PC restored", {8'h0, pc_o}, {8'h0, pc_e});
      chk("R7 busy over", {31'h0, busy_o}, 32'h0);
      exp_sp = exp_sp + 16'd2;
      chk("R7 SP raised by two", {16'h0, sp_o}, {16'h0, exp_sp});
   endtask

   task automatic t_reset();
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      exp_sp = 16'h0100;
      chk("R10 reset status", {24'h0, psr_o}, 32'h0);
      chk("R10 reset PC", {8'h0, pc_o}, 32'h0);
      chk("R10 reset SP", {16'h0, sp_o}, 32'h100);
      chk("R10 reset busy", {31'h0, busy_o}, 32'h0);
   endtask

   task automatic t_wait_boundary();
      sw_psr(8'h1A);
      raise_req(3'd3, 24'h00ABCD, 1'b0);
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R1 no entry before boundary", {30'h0, busy_o, stk_we_o}, 32'h0);
      end
      drop_req();
      tick();
      tick();
      chk("R1 still idle after request drop", {31'h0, busy_o}, 32'h0);
      do_entry(3'd3, 24'h00ABCD, 1'b0, 24'h001234, 8'h1A);
   endtask

   task automatic t_masked_then_nmi();
      raise_req(3'd7, 24'h00BEEF, 1'b0);
      tick();
      insn_done_i = 1'b1; pc_next_i = 24'h00AC00;
      tick();
      insn_done_i = 1'b0;
      drop_req();
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R2 maskable ignored with IE clear", {30'h0, busy_o, stk_we_o}, 32'h0);
      end
      chk("R2 status unchanged by masked request", {24'h0, psr_o}, 32'h6A);
      raise_req(3'd0, 24'h00F000, 1'b1);
      tick();
      do_entry(3'd0, 24'h00F000, 1'b1, 24'h002004, 8'h6A);
      do_reti(8'h6A, 24'h002004);
      do_reti(8'h1A, 24'h001234);
   endtask

   task automatic t_level_edge();
      sw_psr(8'h90);
      raise_req(3'd4, 24'h000400, 1'b0);
      tick();
      insn_done_i = 1'b1; pc_next_i = 24'h003000;
      tick();
      insn_done_i = 1'b0;
      drop_req();
      tick();
      chk("R2 equal level not taken", {31'h0, busy_o}, 32'h0);
      raise_req(3'd5, 24'h000500, 1'b0);
      tick();
      do_entry(3'd5, 24'h000500, 1'b0, 24'h003004, 8'h90);
      do_reti(8'h90, 24'h003004);
   endtask

   task automatic t_wake();
      halt_i = 1'b1;
      raise_req(3'd2, 24'h000600, 1'b0);
      #1;
      chk("R8 no wake for masked level", {31'h0, wake_o}, 32'h0);
      raise_req(3'd6, 24'h000600, 1'b0);
      #1;
      chk("R8 wake on acceptable request", {31'h0, wake_o}, 32'h1);
      tick();
      drop_req();
      tick();
      chk("R8 no entry while halted", {31'h0, busy_o}, 32'h0);
      halt_i = 1'b0;
      tick();
      do_entry(3'd6, 24'h000600, 1'b0, 24'h004002, 8'h90);
      do_reti(8'h90, 24'h004002);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_wait_boundary();
      t_masked_then_nmi();
      t_level_edge();
      t_wake();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule